// File: doc/BRIEF.md
# Reloading Modulus Up-Counter

This block is a 16-bit up-counter that restarts from a modulus latch instead of from zero. Each count step comes from one of eight sources: six prescaler tick enables, or the rising or falling edge of an external clock pin that is first synchronized to the system clock. When the counter steps past 0xFFFF it takes the latch value and sets an overflow flag. A second external pin can also copy the latch into the counter on an edge chosen by software.

Software reaches the counter, the latch and a control/status word through a small word-addressed register port. The flag raises an interrupt request when a non-zero level is programmed. The counter value can be placed on either of two time-base output buses. A bus that is not selected carries zero, so buses from several counters can be ORed together. A global run enable holds the counter until the shared prescaler is started. A freeze request, when enabled, stops the counter while the registers stay accessible.

Top module: `modulus_counter`

## Requirements
- R1: After reset the counter, the latch, the control fields and the overflow flag are all zero, `irqReq` is low and both buses carry 0.
- R2: Clock select values 0 to 5 (control bits [2:0]) advance the counter by one on each cycle in which tick `prescTick[sel]` is high, and on no other tick line.
- R3: Clock select 6 counts rising edges of `extClkPin` and clock select 7 counts its falling edges. A pin change moves the counter on the third rising clock edge after it, not sooner. While a tick-based source is selected, the pin has no effect.
- R4: A count step taken while the counter is 0xFFFF loads the latch value and sets the flag (control bit 15). A latch of 0xFFFF therefore sets the flag on every step, and a latch of 0x0000 gives a free-running wrap.
- R5: A write to address 2 changes only the latch, and the counter keeps its value until the next load. A write to address 1 loads the counter and the latch together.
- R6: The load-edge field (control bits [4:3]: 0 none, 1 rising, 2 falling, 3 both) selects which synchronized edges of `loadPin` copy the latch into the counter.
- R7: While `prescRun` is low no count step happens on any source.
- R8: When the freeze enable (control bit 10) and `freezeReq` are both high, count steps and pin loads stop, register writes still act, and the status bits still follow the pins.
- R9: The flag clears only when control bit 15 is written as 0 after a read of address 0 has returned it as 1. Writing bit 15 as 1 has no effect. `irqReq` is high while the flag is set and the level field (bits [9:7]) is non-zero.
- R10: Control bit 5 places the counter on `busA` and bit 6 places it on `busB`; a bus that is not enabled carries 0.
- R11: Address 0 reads back as the control fields, with bit 13 = synchronized `extClkPin` level, bit 14 = synchronized `loadPin` level, bits 12:11 = 0. Address 3 reads 0 and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| prescTick | input | 6 | Prescaler tick enables, one per tap |
| prescRun | input | 1 | Global prescaler run enable |
| freezeReq | input | 1 | Freeze request from the system |
| extClkPin | input | 1 | Asynchronous external count pin |
| loadPin | input | 1 | Asynchronous modulus-load pin |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address: 0 control, 1 counter, 2 latch |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data |
| irqReq | output | 1 | Overflow interrupt request |
| busA | output | 16 | Time-base bus A output |
| busB | output | 16 | Time-base bus B output |

## Verification
The bound checker watches on every cycle the reload at the 0xFFFF wrap and the flag it sets, the dual load on a counter write, the counter holding still on a latch-only write, while the run enable is low or while frozen, and the request staying low with the flag clear. Only the directed scenarios can show that the right tick line or pin edge was selected, the three-edge synchronizer latency, each load-edge setting, the read-then-write flag clearing sequence and the register readback layout.

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;

  typedef struct packed {
    logic wrCount;
    logic wrLatch;
    logic pinLoad;
    logic step;
  } cnt_strobe_t;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_LATCH = 2'd2;

  localparam int BIT_SEL      = 0;
  localparam int BIT_EDGE     = 3;
  localparam int BIT_DRVA     = 5;
  localparam int BIT_DRVB     = 6;
  localparam int BIT_LVL      = 7;
  localparam int BIT_FRZ      = 10;
  localparam int BIT_EXTLVL   = 13;
  localparam int BIT_LOADLVL  = 14;
  localparam int BIT_FLAG     = 15;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } load_edge_e;

endpackage

// File: rtl/modcnt_sync.sv
module modcnt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= '0;
        else if (s == 0) stage[s] <= asyncIn;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/modcnt_ctrl.sv
module modcnt_ctrl
  import modcnt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NUM_TAPS = 6,
  parameter int SYNC_LEN = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TAPS-1:0] prescTick,
  input  logic                prescRun,
  input  logic                freezeReq,
  input  logic                extClkPin,
  input  logic                loadPin,
  input  logic                regWe,
  input  logic                regRe,
  input  logic [1:0]          regAddr,
  input  logic [CNT_W-1:0]    regWdata,
  input  logic [CNT_W-1:0]    cntVal,
  input  logic [CNT_W-1:0]    latchVal,
  input  logic                wrapEvt,
  output cnt_strobe_t         strb,
  output logic [CNT_W-1:0]    regRdata,
  output logic                irqReq,
  output logic                drvA,
  output logic                drvB,
  output logic                frzEn,
  output logic                ovfFlag
);
  localparam int SEL_W = $clog2(NUM_TAPS + 2);

  logic [SEL_W-1:0] clkSel;
  logic [1:0]       loadEdge;
  logic [2:0]       irqLvl;
  logic             flagArmed;
  logic [1:0]       pinSync;
  logic [1:0]       pinPrev;
  logic             extRise, extFall, ldRise, ldFall;
  logic             tapTick, srcTick, frozen, edgeHit;
  logic             ctrlWr, flagClear;

  modcnt_sync #(.WIDTH(2), .STAGES(SYNC_LEN)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({loadPin, extClkPin}),
    .syncOut(pinSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinSync;
  end

  assign extRise = pinSync[0] & ~pinPrev[0];
  assign extFall = ~pinSync[0] & pinPrev[0];
  assign ldRise  = pinSync[1] & ~pinPrev[1];
  assign ldFall  = ~pinSync[1] & pinPrev[1];

  always_comb begin
    tapTick = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++)
      if (clkSel == SEL_W'(i)) tapTick = prescTick[i];
  end

  always_comb begin
    if (clkSel == SEL_W'(NUM_TAPS))          srcTick = extRise;
    else if (clkSel == SEL_W'(NUM_TAPS + 1)) srcTick = extFall;
    else                                     srcTick = tapTick;
  end

  always_comb begin
    unique case (load_edge_e'(loadEdge))
      EDGE_RISE: edgeHit = ldRise;
      EDGE_FALL: edgeHit = ldFall;
      EDGE_BOTH: edgeHit = ldRise | ldFall;
      default:   edgeHit = 1'b0;
    endcase
  end

  assign frozen       = frzEn & freezeReq;
  assign strb.step    = prescRun & ~frozen & srcTick;
  assign strb.pinLoad = ~frozen & edgeHit;
  assign strb.wrCount = regWe & (regAddr == ADDR_COUNT);
  assign strb.wrLatch = regWe & (regAddr == ADDR_LATCH);

  assign ctrlWr    = regWe & (regAddr == ADDR_CTRL);
  assign flagClear = ctrlWr & ~regWdata[BIT_FLAG] & flagArmed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSel   <= '0;
      loadEdge <= '0;
      drvA     <= 1'b0;
      drvB     <= 1'b0;
      irqLvl   <= '0;
      frzEn    <= 1'b0;
    end else if (ctrlWr) begin
      clkSel   <= regWdata[BIT_SEL +: SEL_W];
      loadEdge <= regWdata[BIT_EDGE +: 2];
      drvA     <= regWdata[BIT_DRVA];
      drvB     <= regWdata[BIT_DRVB];
      irqLvl   <= regWdata[BIT_LVL +: 3];
      frzEn    <= regWdata[BIT_FRZ];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag   <= 1'b0;
      flagArmed <= 1'b0;
    end else begin
      if (wrapEvt)        ovfFlag <= 1'b1;
      else if (flagClear) ovfFlag <= 1'b0;
      if (flagClear)                                          flagArmed <= 1'b0;
      else if (regRe && regAddr == ADDR_CTRL && ovfFlag)      flagArmed <= 1'b1;
    end
  end

  assign irqReq = ovfFlag & (irqLvl != 3'd0);

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CTRL: begin
        regRdata[BIT_SEL +: SEL_W] = clkSel;
        regRdata[BIT_EDGE +: 2]    = loadEdge;
        regRdata[BIT_DRVA]         = drvA;
        regRdata[BIT_DRVB]         = drvB;
        regRdata[BIT_LVL +: 3]     = irqLvl;
        regRdata[BIT_FRZ]          = frzEn;
        regRdata[BIT_EXTLVL]       = pinSync[0];
        regRdata[BIT_LOADLVL]      = pinSync[1];
        regRdata[BIT_FLAG]         = ovfFlag;
      end
      ADDR_COUNT: regRdata = cntVal;
      ADDR_LATCH: regRdata = latchVal;
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/modcnt_datapath.sv
module modcnt_datapath
  import modcnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strobe_t      strb,
  input  logic [CNT_W-1:0] wrData,
  input  logic             drvA,
  input  logic             drvB,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] latchVal,
  output logic             wrapEvt,
  output logic [CNT_W-1:0] busA,
  output logic [CNT_W-1:0] busB
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic atMax;
  assign atMax   = (cntVal == CNT_MAX);
  assign wrapEvt = strb.step & atMax & ~strb.wrCount & ~strb.pinLoad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal   <= '0;
      latchVal <= '0;
    end else if (strb.wrCount) begin
      cntVal   <= wrData;
      latchVal <= wrData;
    end else begin
      if (strb.wrLatch) latchVal <= wrData;
      if (strb.pinLoad)   cntVal <= latchVal;
      else if (strb.step) cntVal <= atMax ? latchVal : cntVal + 1'b1;
    end
  end

  assign busA = drvA ? cntVal : '0;
  assign busB = drvB ? cntVal : '0;
endmodule

// File: rtl/modulus_counter.sv
module modulus_counter
  import modcnt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NUM_TAPS = 6,
  parameter int SYNC_LEN = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TAPS-1:0] prescTick,
  input  logic                prescRun,
  input  logic                freezeReq,
  input  logic                extClkPin,
  input  logic                loadPin,
  input  logic                regWe,
  input  logic                regRe,
  input  logic [1:0]          regAddr,
  input  logic [CNT_W-1:0]    regWdata,
  output logic [CNT_W-1:0]    regRdata,
  output logic                irqReq,
  output logic [CNT_W-1:0]    busA,
  output logic [CNT_W-1:0]    busB
);
  cnt_strobe_t      strb;
  logic [CNT_W-1:0] cntVal, latchVal;
  logic             wrapEvt, drvA, drvB, frzEn, ovfFlag;

  modcnt_ctrl #(.CNT_W(CNT_W), .NUM_TAPS(NUM_TAPS), .SYNC_LEN(SYNC_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .prescTick(prescTick), .prescRun(prescRun),
    .freezeReq(freezeReq), .extClkPin(extClkPin), .loadPin(loadPin),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .regWdata(regWdata),
    .cntVal(cntVal), .latchVal(latchVal), .wrapEvt(wrapEvt), .strb(strb),
    .regRdata(regRdata), .irqReq(irqReq), .drvA(drvA), .drvB(drvB),
    .frzEn(frzEn), .ovfFlag(ovfFlag)
  );

  modcnt_datapath #(.CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWdata),
    .drvA(drvA), .drvB(drvB), .cntVal(cntVal), .latchVal(latchVal),
    .wrapEvt(wrapEvt), .busA(busA), .busB(busB)
  );
endmodule

// File: rtl/modcnt_checker.sv
module modcnt_checker
  import modcnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input cnt_strobe_t      strb,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] latchVal,
  input logic [CNT_W-1:0] regWdata,
  input logic             prescRun,
  input logic             freezeReq,
  input logic             frzEn,
  input logic             ovfFlag,
  input logic             irqReq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && cntVal == CNT_MAX && !strb.wrCount && !strb.pinLoad)
      |=> (cntVal == $past(latchVal) && ovfFlag));

  a_r5_count_write_both: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCount |=> (cntVal == $past(regWdata) && latchVal == $past(regWdata)));

  a_r5_latch_write_only: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrLatch && !strb.wrCount && !strb.step && !strb.pinLoad)
      |=> ($stable(cntVal) && latchVal == $past(regWdata)));

  a_r7_halt_without_run: assert property (@(posedge clk) disable iff (!rstN)
    (!prescRun && !strb.wrCount && !strb.pinLoad) |=> $stable(cntVal));

  a_r8_freeze_holds: assert property (@(posedge clk) disable iff (!rstN)
    (freezeReq && frzEn && !strb.wrCount) |=> $stable(cntVal));

  a_r9_no_irq_without_flag: assert property (@(posedge clk) disable iff (!rstN)
    !ovfFlag |-> !irqReq);
endmodule

bind modulus_counter modcnt_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .cntVal(cntVal), .latchVal(latchVal),
  .regWdata(regWdata), .prescRun(prescRun), .freezeReq(freezeReq),
  .frzEn(frzEn), .ovfFlag(ovfFlag), .irqReq(irqReq)
);

// File: tb/tb_modulus_counter.sv
`timescale 1ns/1ps
module tb_modulus_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  prescTick = '0;
  logic        prescRun = 1'b0;
  logic        freezeReq = 1'b0;
  logic        extClkPin = 1'b0;
  logic        loadPin = 1'b0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        irqReq;
  logic [15:0] busA, busB;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  modulus_counter dut (
    .clk(clk), .rstN(rstN), .prescTick(prescTick), .prescRun(prescRun),
    .freezeReq(freezeReq), .extClkPin(extClkPin), .loadPin(loadPin),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqReq(irqReq), .busA(busA), .busB(busB)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input logic [2:0] sel, input logic [1:0] edg,
                                     input logic dA, input logic dB,
                                     input logic [2:0] lvl, input logic frz);
    return {1'b1, 4'b0, frz, lvl, dB, dA, edg, sel};
  endfunction

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic tick(input int idx);
    @(negedge clk);
    prescTick[idx] = 1'b1;
    @(negedge clk);
    prescTick = '0;
  endtask

  task automatic pinSettle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearFlag(input logic [15:0] ctl);
    logic [15:0] d;
    rdReg(0, d);
    wrReg(0, ctl & 16'h7FFF);
  endtask

  task automatic testReset();
    logic [15:0] d;
    rdReg(0, d); chk("R1 control after reset", d, 16'h0000);
    rdReg(1, d); chk("R1 counter after reset", d, 16'h0000);
    rdReg(2, d); chk("R1 latch after reset", d, 16'h0000);
    chk("R1 irq after reset", {15'b0, irqReq}, 16'h0000);
    chk("R1 busA after reset", busA, 16'h0000);
    chk("R1 busB after reset", busB, 16'h0000);
  endtask

  task automatic testTaps();
    logic [15:0] d;
    prescRun = 1'b1;
    wrReg(0, cw(3'd2, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0));
    wrReg(1, 16'h0000);
    tick(0); tick(3); tick(5);
    rdReg(1, d); chk("R2 other taps ignored", d, 16'h0000);
    tick(2); tick(2);
    rdReg(1, d); chk("R2 selected tap counts", d, 16'h0002);
    wrReg(0, cw(3'd5, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0));
    tick(2); tick(5);
    rdReg(1, d); chk("R2 tap 5 selected", d, 16'h0003);
    prescRun = 1'b0;
    tick(5); tick(5);
    rdReg(1, d); chk("R7 no count without run", d, 16'h0003);
    prescRun = 1'b1;
    tick(5);
    rdReg(1, d); chk("R7 counts again with run", d, 16'h0004);
  endtask

  task automatic testWrites();
    logic [15:0] d;
    wrReg(0, cw(3'd2, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0));
    wrReg(1, 16'h1234);
    rdReg(1, d); chk("R5 counter write", d, 16'h1234);
    rdReg(2, d); chk("R5 counter write also latch", d, 16'h1234);
    wrReg(2, 16'h0100);
    rdReg(1, d); chk("R5 latch write leaves counter", d, 16'h1234);
    rdReg(2, d); chk("R5 latch write value", d, 16'h0100);
  endtask

  task automatic testOverflow();
    logic [15:0] d;
    logic [15:0] ctl0 = cw(3'd2, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0);
    logic [15:0] ctl3 = cw(3'd2, 2'd0, 1'b0, 1'b0, 3'd3, 1'b0);
    wrReg(0, ctl0);
    wrReg(1, 16'hFFFE);
    wrReg(2, 16'h0010);
    tick(2);
    rdReg(1, d); chk("R4 step to FFFF", d, 16'hFFFF);
    chk("R4 no flag before wrap", {15'b0, irqReq}, 16'h0000);
    tick(2);
    rdReg(1, d); chk("R4 wrap loads latch", d, 16'h0010);
    chk("R9 irq low with level 0", {15'b0, irqReq}, 16'h0000);
    rdReg(0, d); chk("R4 flag set on wrap", d & 16'h8000, 16'h8000);
    wrReg(0, ctl3);
    chk("R9 irq with level 3", {15'b0, irqReq}, 16'h0001);
    wrReg(0, ctl3 & 16'h7FFF);
    chk("R9 read then write 0 clears", {15'b0, irqReq}, 16'h0000);
    wrReg(1, 16'hFFFF);
    wrReg(2, 16'h0010);
    tick(2);
    chk("R9 flag set again", {15'b0, irqReq}, 16'h0001);
    wrReg(0, ctl3 & 16'h7FFF);
    chk("R9 clear without read ignored", {15'b0, irqReq}, 16'h0001);
    clearFlag(ctl3);
    chk("R9 clear after read", {15'b0, irqReq}, 16'h0000);
    wrReg(1, 16'hFFFF);
    tick(2);
    rdReg(1, d); chk("R4 latch FFFF reloads FFFF", d, 16'hFFFF);
    chk("R4 latch FFFF flag first", {15'b0, irqReq}, 16'h0001);
    clearFlag(ctl3);
    tick(2);
    chk("R4 latch FFFF flag every step", {15'b0, irqReq}, 16'h0001);
    clearFlag(ctl3);
    wrReg(1, 16'hFFFF);
    wrReg(2, 16'h0000);
    tick(2); tick(2);
    rdReg(1, d); chk("R4 latch 0 free-running", d, 16'h0001);
    clearFlag(ctl0);
  endtask

  task automatic testExtClock();
    logic [15:0] d;
    wrReg(0, cw(3'd6, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0));
    wrReg(1, 16'h0000);
    tick(2);
    rdReg(1, d); chk("R3 tap ignored with pin source", d, 16'h0000);
    @(negedge clk);
    regAddr = 2'd1;
    extClkPin = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk("R3 not counted before third edge", regRdata, 16'h0000);
    @(posedge clk);
    #1 chk("R3 counted on third edge", regRdata, 16'h0001);
    @(negedge clk); extClkPin = 1'b0;
    pinSettle();
    rdReg(1, d); chk("R3 falling ignored in rising mode", d, 16'h0001);
    wrReg(0, cw(3'd7, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0));
    extClkPin = 1'b1; pinSettle();
    rdReg(1, d); chk("R3 rising ignored in falling mode", d, 16'h0001);
    rdReg(0, d); chk("R11 ext level status", d & 16'h2000, 16'h2000);
    extClkPin = 1'b0; pinSettle();
    rdReg(1, d); chk("R3 falling edge counts", d, 16'h0002);
    wrReg(0, cw(3'd2, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0));
    extClkPin = 1'b1; pinSettle();
    extClkPin = 1'b0; pinSettle();
    rdReg(1, d); chk("R3 pin ignored with tap source", d, 16'h0002);
  endtask

  task automatic loadCase(input logic [1:0] edg, input logic lvl, input logic [15:0] exp,
                          input string tag);
    logic [15:0] d;
    wrReg(1, 16'h0100);
    wrReg(2, 16'h0500);
    loadPin = lvl; pinSettle();
    rdReg(1, d); chk(tag, d, exp);
  endtask

  task automatic testLoadPin();
    wrReg(0, cw(3'd2, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0));
    loadCase(2'd1, 1'b1, 16'h0500, "R6 rising loads in rising mode");
    loadCase(2'd1, 1'b0, 16'h0100, "R6 falling ignored in rising mode");
    wrReg(0, cw(3'd2, 2'd2, 1'b0, 1'b0, 3'd0, 1'b0));
    loadCase(2'd2, 1'b1, 16'h0100, "R6 rising ignored in falling mode");
    loadCase(2'd2, 1'b0, 16'h0500, "R6 falling loads in falling mode");
    wrReg(0, cw(3'd2, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0));
    loadCase(2'd0, 1'b1, 16'h0100, "R6 none mode rising ignored");
    loadCase(2'd0, 1'b0, 16'h0100, "R6 none mode falling ignored");
    wrReg(0, cw(3'd2, 2'd3, 1'b0, 1'b0, 3'd0, 1'b0));
    loadCase(2'd3, 1'b1, 16'h0500, "R6 both mode rising");
    loadCase(2'd3, 1'b0, 16'h0500, "R6 both mode falling");
  endtask

  task automatic testFreeze();
    logic [15:0] d;
    wrReg(0, cw(3'd2, 2'd1, 1'b0, 1'b0, 3'd0, 1'b1));
    freezeReq = 1'b1;
    wrReg(1, 16'h0042);
    rdReg(1, d); chk("R8 write while frozen", d, 16'h0042);
    wrReg(2, 16'h0700);
    tick(2);
    rdReg(1, d); chk("R8 no step while frozen", d, 16'h0042);
    loadPin = 1'b1; extClkPin = 1'b1; pinSettle();
    rdReg(1, d); chk("R8 no pin load while frozen", d, 16'h0042);
    rdReg(0, d); chk("R8 pin levels still shown", d & 16'h6000, 16'h6000);
    wrReg(0, cw(3'd2, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0));
    tick(2);
    rdReg(1, d); chk("R8 freeze ignored when disabled", d, 16'h0043);
    freezeReq = 1'b0;
    loadPin = 1'b0; extClkPin = 1'b0; pinSettle();
  endtask

  task automatic testBusAndMap();
    logic [15:0] d;
    wrReg(0, cw(3'd2, 2'd0, 1'b1, 1'b0, 3'd0, 1'b0));
    wrReg(1, 16'h5A5A);
    chk("R10 busA driven", busA, 16'h5A5A);
    chk("R10 busB idle", busB, 16'h0000);
    wrReg(0, cw(3'd2, 2'd0, 1'b0, 1'b1, 3'd0, 1'b0));
    chk("R10 busA idle", busA, 16'h0000);
    chk("R10 busB driven", busB, 16'h5A5A);
    wrReg(3, 16'hFFFF);
    rdReg(3, d); chk("R11 address 3 reads 0", d, 16'h0000);
    rdReg(1, d); chk("R11 address 3 write no effect", d, 16'h5A5A);
    wrReg(0, cw(3'd5, 2'd2, 1'b1, 1'b0, 3'd4, 1'b1) | 16'h1800);
    rdReg(0, d);
    chk("R11 control readback", d, cw(3'd5, 2'd2, 1'b1, 1'b0, 3'd4, 1'b1) & 16'h07FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTaps();
    testWrites();
    testOverflow();
    testExtClock();
    testLoadPin();
    testFreeze();
    testBusAndMap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule